// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned words of a parameterised width together with a single carry-in bit. It returns a sum word of the same width and a carry-out bit. It is purely combinational. It is meant to sit inside a wider datapath where a ripple chain would be too slow for the clock period.

Every internal carry is found by one prefix scan rather than passed bit by bit.

- Each bit position is reduced to a three-valued digit: the count of set operand bits, which is 0, 1 or 2.
  - 0 means kill: the carry is stopped.
  - 1 means propagate: the carry passes through.
  - 2 means generate: a carry is produced.
- The carry-in adds one more digit below bit 0. That digit is a generate when the carry-in is set and a kill when it is clear.
- A recursive tree of logarithmic depth scans the digits with an associative rule. If the upper digit is a propagate, the lower digit's result is kept. Otherwise the upper digit decides.
- The carry into each bit is set exactly when the scanned digit just below it resolves to generate.
- Each sum bit is the XOR of the two operand bits and that carry.

Top module: `prefix_adder`

## Requirements
- R1: For all inputs, sum_o + 2^WIDTH * cout_o equals a_i + b_i + cin_i.
- R2: The carry-in acts as a generate digit below bit 0: with a_i = b_i = 0 and cin_i = 1, sum_o is 1 and cout_o is 0.
- R3: When both operand bits at position i are 1, the carry out of position i is 1 whatever the lower bits hold.
- R4: When both operand bits at position i are 0, the carry out of position i is 0 whatever the lower bits hold.
- R5: When exactly one operand bit at position i is 1, the carry out of position i equals the carry into position i.
- R6: With b_i = ~a_i, every position propagates. For cin_i = 0 the result is sum_o all ones with cout_o = 0. For cin_i = 1 it is sum_o = 0 with cout_o = 1.
- R7: Each sum bit equals a_i[i] XOR b_i[i] XOR the carry into position i, where the carry into position 0 is cin_i.
- R8: With WIDTH = 4, a_i = 4'b0110, b_i = 4'b0011 and cin_i = 0, the result is sum_o = 4'b1001 and cout_o = 0.
- R9: The carry network has depth proportional to log2(WIDTH) and cell count proportional to WIDTH. The result is correct for any WIDTH of at least 1, including 8 and 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First addend |
| b_i | input | WIDTH | Second addend |
| cin_i | input | 1 | Carry-in, weight 1 |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Carry-out, weight 2^WIDTH |

## Verification
The bench targets three kinds of case, each of which exposes a different wrong combine rule or wrong scan shape.

- Long propagate runs, where b is the complement of a, with and without carry-in. A combine rule that lets a propagate override a lower generate would clear the carry-out and leave the sum all ones instead of zero.
- A kill digit sitting just above a long generated carry. A tree that wires the wrong pair of neighbours in its odd or even fix-up would let that carry leak past the kill into the top bit.
- The carry-in alone on zero operands, the worked 4-bit example, a full exhaustive sweep at width 8, and random words at width 64 where tree depth matters. An off-by-one in the position of the carry-in digit would shift every carry by one bit and corrupt the sum throughout.

// File: rtl/adder_pkg.sv
package adder_pkg;

    // Three-valued digit: number of set operand bits at a position
    typedef enum logic [1:0] {
        DIG_KILL = 2'd0,
        DIG_PROP = 2'd1,
        DIG_GEN  = 2'd2
    } digit_t;

    // Associative scan operator: a propagate above defers to the lower result
    function automatic digit_t dig_combine(input digit_t upper, input digit_t lower);
        return (upper == DIG_PROP) ? lower : upper;
    endfunction

endpackage

// File: rtl/digit_encode.sv
module digit_encode
    import adder_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int NDIG = WIDTH + 1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output digit_t           dig_o [NDIG]
);

    // Slot 0 holds the carry-in digit; slot i+1 holds bit position i
    always_comb begin
        dig_o[0] = cin_i ? DIG_GEN : DIG_KILL;
        for (int i = 0; i < WIDTH; i++) begin
            dig_o[i+1] = digit_t'({a_i[i] & b_i[i], a_i[i] ^ b_i[i]});
        end
    end

endmodule

// File: rtl/prefix_scan.sv
module prefix_scan
    import adder_pkg::*;
#(
    parameter int WIDTH = 33
) (
    input  digit_t dig_i [WIDTH],
    output digit_t pre_o [WIDTH]
);

    generate
        if (WIDTH == 1) begin : g_leaf
            assign pre_o[0] = dig_i[0];
        end else begin : g_node
            localparam int HALF = WIDTH / 2;

            digit_t pair_w [HALF];
            digit_t sub_w  [HALF];

            // Reduce adjacent pairs
            for (genvar k = 0; k < HALF; k++) begin : g_pair
                assign pair_w[k] = dig_combine(dig_i[2*k+1], dig_i[2*k]);
            end

            // Scan the half-length sequence
            prefix_scan #(.WIDTH(HALF)) i_sub (
                .dig_i (pair_w),
                .pre_o (sub_w)
            );

            assign pre_o[0] = dig_i[0];

            // Odd slots come straight from the half-size scan
            for (genvar k = 0; k < HALF; k++) begin : g_odd
                assign pre_o[2*k+1] = sub_w[k];
            end

            // Even slots need one more combine with the prefix below them
            for (genvar k = 1; 2*k < WIDTH; k++) begin : g_even
                assign pre_o[2*k] = dig_combine(dig_i[2*k], sub_w[k-1]);
            end
        end
    endgenerate

endmodule

// File: rtl/sum_form.sv
module sum_form
    import adder_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int NDIG = WIDTH + 1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  digit_t           pre_i [NDIG],
    output logic [WIDTH:0]   carry_o,
    output logic [WIDTH-1:0] sum_o
);

    // carry_o[i] is the carry into position i; it is set when slot i resolved to generate
    always_comb begin
        for (int i = 0; i < NDIG; i++) begin
            carry_o[i] = (pre_i[i] == DIG_GEN);
        end
        sum_o = a_i ^ b_i ^ carry_o[WIDTH-1:0];
    end

endmodule

// File: rtl/prefix_adder.sv
module prefix_adder
    import adder_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int NDIG = WIDTH + 1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    digit_t           dig_w   [NDIG];
    digit_t           pre_w   [NDIG];
    logic [WIDTH:0]   carry_w;

    digit_encode #(.WIDTH(WIDTH)) i_encode (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (cin_i),
        .dig_o (dig_w)
    );

    prefix_scan #(.WIDTH(NDIG)) i_scan (
        .dig_i (dig_w),
        .pre_o (pre_w)
    );

    sum_form #(.WIDTH(WIDTH)) i_sum (
        .a_i     (a_i),
        .b_i     (b_i),
        .pre_i   (pre_w),
        .carry_o (carry_w),
        .sum_o   (sum_o)
    );

    assign cout_o = carry_w[WIDTH];

    // Checks between operand bits and the carries resolved by the scan
    always_comb begin
        a_r1_value: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
            else $error("R1 adder total mismatch");
        a_r2_carry_in: assert (carry_w[0] == cin_i)
            else $error("R2 carry into bit 0 differs from carry-in");
        for (int i = 0; i < WIDTH; i++) begin
            a_r3_generate: assert (!(a_i[i] && b_i[i]) || carry_w[i+1])
                else $error("R3 generate position lost its carry");
            a_r4_kill: assert (a_i[i] || b_i[i] || !carry_w[i+1])
                else $error("R4 kill position produced a carry");
            a_r5_propagate: assert (!(a_i[i] ^ b_i[i]) || (carry_w[i+1] == carry_w[i]))
                else $error("R5 propagate position altered the carry");
        end
    end

endmodule

// File: tb/test_prefix_adder.sv
module test_prefix_adder;

    localparam int W8  = 8;
    localparam int W64 = 64;
    localparam int W4  = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W8-1:0]  a8, b8, s8;
    logic           c8, co8;
    logic [W64-1:0] a64, b64, s64;
    logic           c64, co64;
    logic [W4-1:0]  a4, b4, s4;
    logic           c4, co4;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    prefix_adder #(.WIDTH(W8)) i_prefix_adder (
        .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8));
    prefix_adder #(.WIDTH(W64)) i_prefix_adder_w64 (
        .a_i(a64), .b_i(b64), .cin_i(c64), .sum_o(s64), .cout_o(co64));
    prefix_adder #(.WIDTH(W4)) i_prefix_adder_w4 (
        .a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4), .cout_o(co4));

    function automatic logic [W8:0] ref8(input logic [W8-1:0] a, input logic [W8-1:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {{W8{1'b0}}, c};
    endfunction

    function automatic logic [W64:0] ref64(input logic [W64-1:0] a, input logic [W64-1:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {{W64{1'b0}}, c};
    endfunction

    task automatic chk8(input string req);
        logic [W8:0] e;
        e = ref8(a8, b8, c8);
        checks++;
        if ({co8, s8} !== e) begin
            fails++;
            $display("FAIL %s w8 a=%h b=%h c=%b actual=%h expected=%h", req, a8, b8, c8, {co8, s8}, e);
        end
    endtask

    task automatic chk64(input string req);
        logic [W64:0] e;
        e = ref64(a64, b64, c64);
        checks++;
        if ({co64, s64} !== e) begin
            fails++;
            $display("FAIL %s w64 a=%h b=%h c=%b actual=%h expected=%h", req, a64, b64, c64, {co64, s64}, e);
        end
    endtask

    task automatic chk_val(input string req, input logic [W64:0] act, input logic [W64:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs change after the rising edge; outputs are read at the falling edge
    task automatic drive8(input logic [W8-1:0] a, input logic [W8-1:0] b, input logic c);
        @(posedge clk);
        a8 = a; b8 = b; c8 = c;
        @(negedge clk);
    endtask

    task automatic drive64(input logic [W64-1:0] a, input logic [W64-1:0] b, input logic c);
        @(posedge clk);
        a64 = a; b64 = b; c64 = c;
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1234);
        a8 = '0; b8 = '0; c8 = 1'b0;
        a64 = '0; b64 = '0; c64 = 1'b0;
        a4 = '0; b4 = '0; c4 = 1'b0;
        @(negedge clk);

        // Idle state: zero operands give zero result
        chk_val("R1 idle w8", {{(W64-W8){1'b0}}, co8, s8}, '0);
        chk_val("R1 idle w64", {co64, s64}, '0);

        // R8 worked example on the 4-bit instance
        @(posedge clk);
        a4 = 4'b0110; b4 = 4'b0011; c4 = 1'b0;
        @(negedge clk);
        chk_val("R8 worked example", {{(W64-W4){1'b0}}, co4, s4}, {{(W64-W4){1'b0}}, 1'b0, 4'b1001});

        // R2 carry-in alone
        drive8('0, '0, 1'b1);
        chk_val("R2 carry-in only", {{(W64-W8){1'b0}}, co8, s8}, 65'd1);
        drive64('0, '0, 1'b1);
        chk_val("R2 carry-in only w64", {co64, s64}, 65'd1);

        // R3 top-bit generate
        drive8(8'h80, 8'h80, 1'b0);
        chk_val("R3 top generate", {{(W64-W8){1'b0}}, co8, s8}, {{(W64-W8){1'b0}}, 1'b1, 8'h00});

        // R4 kill above a long carry: 0x7F + 0x01 stops at bit 7
        drive8(8'h7F, 8'h01, 1'b0);
        chk_val("R4 kill blocks carry", {{(W64-W8){1'b0}}, co8, s8}, {{(W64-W8){1'b0}}, 1'b0, 8'h80});
        drive64(64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
        chk_val("R4 kill at top w64", {co64, s64}, {1'b0, 64'h8000_0000_0000_0000});

        // R5 / R6 all-propagate with both carry-in values
        drive8(8'hA5, 8'h5A, 1'b0);
        chk_val("R6 propagate cin0", {{(W64-W8){1'b0}}, co8, s8}, {{(W64-W8){1'b0}}, 1'b0, 8'hFF});
        drive8(8'hA5, 8'h5A, 1'b1);
        chk_val("R5 R6 propagate cin1", {{(W64-W8){1'b0}}, co8, s8}, {{(W64-W8){1'b0}}, 1'b1, 8'h00});
        drive64(64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b0);
        chk_val("R6 propagate cin0 w64", {co64, s64}, {1'b0, {W64{1'b1}}});
        drive64(64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b1);
        chk_val("R6 propagate cin1 w64", {co64, s64}, {1'b1, {W64{1'b0}}});

        // Max operands
        drive64('1, '1, 1'b1);
        chk_val("R3 all generate w64", {co64, s64}, {1'b1, {W64{1'b1}}});

        // R1 R7 R9: exhaustive sweep at width 8, random width 64 in parallel
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    @(posedge clk);
                    a8 = a[7:0]; b8 = b[7:0]; c8 = c[0];
                    a64 = {$urandom, $urandom};
                    b64 = {$urandom, $urandom};
                    if (b[2:0] == 3'd0) b64 = ~a64;
                    if (b[2:0] == 3'd1) b64 = ~a64 ^ (64'd1 << a[5:0]);
                    c64 = $urandom % 2;
                    @(negedge clk);
                    chk8("R1 R7 R9 exhaustive");
                    chk64("R1 R7 R9 random");
                end
            end
        end

        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 150000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule